// File: doc/BRIEF.md
# SPI Register Port with Streaming RAM Window

This block is an SPI slave that sits in the system clock domain and gives a host access to a 30-location, 8-bit register space. The first byte of every chip-select frame is a command that names a direction and a starting register. The bytes that follow are data bytes, and they move in a burst. Locations 0x00 to 0x19 are ordinary registers. They are reached through a simple register-file port (a write strobe with its address and data, and a read address with returned data), so the registers themselves live outside the block.

The top four locations form a window onto a 512-byte RAM held inside the block. Two of these locations hold a 9-bit RAM pointer. The other two are data ports. A burst aimed at a data port streams bytes through the auto-advancing pointer and does not step the register address.

The SPI pins are oversampled by the system clock. Each SCK half-period must therefore last at least four system clock cycles.

Top module: `spi_regport_ram`

## Requirements
- R1: A command is valid when its bits [6:5] are 01. Bit 7 selects the direction (1 = read, 0 = write) and bits [4:0] give the start address. Command values are therefore 0x20 OR address for a write and 0xA0 OR address for a read.
- R2: Within a burst, the address advances by one after each data byte while it is below 0x1C. A write byte to 0x00–0x19 appears on the register-file write port. A read byte from 0x00–0x19 returns `reg_rdata` for the address shown on `reg_raddr`.
- R3: Address 0x1A holds the pointer's high part (bit 0 = pointer bit 8, the other bits read 0). Address 0x1B holds pointer bits [7:0]. Both can be written and read back.
- R4: A data byte written at 0x1C is stored in RAM at the pointer, and a data byte read at 0x1D returns RAM at the pointer. The pointer advances by one for each completed byte of either kind.
- R5: The pointer wraps from 511 to 0.
- R6: A command whose bits [6:5] are not 01, or whose address exceeds 0x1D, makes the rest of the frame inert. Nothing is written, the pointer does not move, and MISO stays 0 until chip select rises.
- R7: During a burst at 0x1C or 0x1D the address stays fixed. A write burst that starts at 0x1A loads both pointer bytes and then streams the bytes that follow into RAM.
- R8: Writing to 0x1D changes nothing. Reading 0x1C returns 0x00 and does not move the pointer.
- R9: A byte whose eighth rising SCK edge arrives in the same sampled cycle as chip-select release is discarded.
- R10: The link uses SPI mode 0, MSB first. MISO is 0 while chip select is high and during the command byte. The first read byte is driven from the SCK falling edge that follows the command byte.
- R11: `reg_we` is a one-cycle pulse for each completed write byte whose address is below 0x1A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_we | output | 1 | Register-file write strobe |
| reg_waddr | output | 5 | Register-file write address |
| reg_wdata | output | 8 | Register-file write data |
| reg_raddr | output | 5 | Register-file read address |
| reg_rdata | input | 8 | Register-file read data |

## Verification
Two events can land in the same sampled system cycle: completion of a byte on its eighth SCK rise, and release of chip select. The bench provokes this by raising SCK and chip select at the same instant, which sends both through identical synchronizers. It judges the outcome by reading the target register back in a fresh frame and requiring it unchanged, with no write strobe counted. A second overlap is also exercised. When a pointer advance from RAM streaming coincides with the 511-to-0 wrap, the bench reads the pointer back through 0x1A/0x1B and reads the wrapped RAM bytes through 0x1D.

// File: rtl/spi_rw_pkg.sv
`timescale 1ns/1ps
package spi_rw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] REG_LAST   = 5'h1D;
  localparam logic [REG_AW-1:0] OFS_PTR_HI = 5'h1A;
  localparam logic [REG_AW-1:0] OFS_PTR_LO = 5'h1B;
  localparam logic [REG_AW-1:0] OFS_RAM_WR = 5'h1C;
  localparam logic [REG_AW-1:0] OFS_RAM_RD = 5'h1D;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_SKIP} phase_t;

  typedef struct packed {
    logic              ok;
    logic              rd;
    logic [REG_AW-1:0] addr;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c.addr = b[REG_AW-1:0];
    c.rd   = b[7];
    c.ok   = (b[6:5] == 2'b01) && (b[REG_AW-1:0] <= REG_LAST);
    return c;
  endfunction

  function automatic logic [REG_AW-1:0] step_addr(input logic [REG_AW-1:0] a);
    return (a < OFS_RAM_WR) ? a + 1'b1 : a;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] csn_q, sck_q, mosi_q;
  logic              sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= '1;
      sck_q  <= '0;
      mosi_q <= '0;
      sck_d  <= 1'b0;
    end else begin
      csn_q  <= {csn_q[STAGES-2:0], csn_i};
      sck_q  <= {sck_q[STAGES-2:0], sck_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      sck_d  <= sck_q[STAGES-1];
    end
  end

  assign cs_act   = ~csn_q[STAGES-1];
  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign mosi_s   = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
module spi_byte_engine #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_data,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso_bit
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              last_bit, at_boundary;

  assign last_bit    = (bit_cnt == CNT_W'(BYTE_W-1));
  assign at_boundary = (bit_cnt == '0);
  assign byte_done   = cs_act & sck_rise & last_bit;
  assign rx_byte     = {rx_sh[BYTE_W-2:0], mosi_s};
  assign miso_bit    = tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      if (sck_rise) begin
        rx_sh   <= rx_byte;
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end
      if (sck_fall) begin
        if (at_boundary && load_en) tx_sh <= load_data;
        else                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R10: a released chip select leaves the bit counter at a byte boundary
  a_r10_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));
  // R10: with chip select high, nothing is queued for MISO
  a_r10_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (tx_sh == '0));
endmodule

// File: rtl/spi_cmd_ctrl.sv
`timescale 1ns/1ps
module spi_cmd_ctrl
  import spi_rw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output phase_t            phase,
  output logic [REG_AW-1:0] cur_addr,
  output logic              wr_evt,
  output logic              rd_evt
);
  cmd_t cmd;
  assign cmd    = cmd_decode(rx_byte);
  assign wr_evt = byte_done && (phase == PH_WR);
  assign rd_evt = byte_done && (phase == PH_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      cur_addr <= '0;
    end else if (!cs_act) begin
      phase <= PH_CMD;
    end else if (byte_done) begin
      unique case (phase)
        PH_CMD: begin
          if (cmd.ok) begin
            phase    <= cmd.rd ? PH_RD : PH_WR;
            cur_addr <= cmd.addr;
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_WR, PH_RD: cur_addr <= step_addr(cur_addr);
        default: ;
      endcase
    end
  end

  // R6: a rejected frame stays inert while chip select is held
  a_r6_skip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && cs_act) |=> (phase == PH_SKIP));
  // R7: streaming addresses do not step during a burst
  a_r7_stream_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_WR || phase == PH_RD) && cur_addr >= OFS_RAM_WR)
      |=> (cur_addr == $past(cur_addr)));
  // R9: chip-select release returns to command decode
  a_r9_release_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase == PH_CMD));
endmodule

// File: rtl/spi_ram_window.sv
`timescale 1ns/1ps
module spi_ram_window
  import spi_rw_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] ram_q
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic              ram_wr, ptr_adv;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign ram_wr  = wr_evt && (addr == OFS_RAM_WR);
  assign ptr_adv = ram_wr || (rd_evt && (addr == OFS_RAM_RD));
  assign ram_q   = mem[ptr];

  always_ff @(posedge clk) begin
    if (ram_wr) mem[ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_evt && addr == OFS_PTR_HI) begin
      ptr[PTR_W-1:BYTE_W] <= wdata[PTR_W-BYTE_W-1:0];
    end else if (wr_evt && addr == OFS_PTR_LO) begin
      ptr[BYTE_W-1:0] <= wdata;
    end else if (ptr_adv) begin
      ptr <= ptr_next(ptr);
    end
  end

  // R5: the last RAM location is followed by location zero
  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && ptr == PTR_W'(DEPTH-1)) |=> (ptr == '0));
  // R4: each streamed byte moves the pointer by exactly one
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && ptr != PTR_W'(DEPTH-1)) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
  // R4: the pointer holds when no byte completes
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !rd_evt) |=> $stable(ptr));
endmodule

// File: rtl/spi_regport_ram.sv
`timescale 1ns/1ps
module spi_regport_ram
  import spi_rw_pkg::*;
#(
  parameter int unsigned RAM_DEPTH   = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic [REG_AW-1:0] reg_raddr,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int unsigned PTR_W = $clog2(RAM_DEPTH);

  logic              cs_act, sck_rise, sck_fall, mosi_s;
  logic              byte_done, miso_bit, wr_evt, rd_evt;
  logic [BYTE_W-1:0] rx_byte, load_data, ram_q;
  logic [REG_AW-1:0] cur_addr;
  logic [PTR_W-1:0]  ptr;
  phase_t            phase;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .csn_i(spi_csn), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s));

  spi_byte_engine #(.BYTE_W(BYTE_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .load_en(phase == PH_RD),
    .load_data(load_data), .byte_done(byte_done), .rx_byte(rx_byte),
    .miso_bit(miso_bit));

  spi_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte), .phase(phase), .cur_addr(cur_addr),
    .wr_evt(wr_evt), .rd_evt(rd_evt));

  spi_ram_window #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .addr(cur_addr), .wdata(rx_byte), .ptr(ptr), .ram_q(ram_q));

  always_comb begin
    unique case (cur_addr)
      OFS_PTR_HI: load_data = BYTE_W'(ptr[PTR_W-1:BYTE_W]);
      OFS_PTR_LO: load_data = ptr[BYTE_W-1:0];
      OFS_RAM_WR: load_data = '0;
      OFS_RAM_RD: load_data = ram_q;
      default:    load_data = reg_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= wr_evt && (cur_addr < OFS_PTR_HI);
      if (wr_evt && cur_addr < OFS_PTR_HI) begin
        reg_waddr <= cur_addr;
        reg_wdata <= rx_byte;
      end
    end
  end

  assign reg_raddr = cur_addr;
  assign spi_miso  = cs_act & miso_bit;

  // R11: one strobe per completed byte
  a_r11_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R11: strobes only reach ordinary registers
  a_r11_waddr_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_waddr < OFS_PTR_HI));
  // R10: MISO is silent whenever chip select is released
  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> !spi_miso);
endmodule

// File: tb/spi_regport_ram_tb.sv
`timescale 1ns/1ps
module spi_regport_ram_tb;
  localparam int HALF = 6;
  localparam int DEPTH = 512;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso, reg_we;
  logic [4:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;

  int total = 0, bad = 0, we_cnt = 0;
  bit done = 0;

  logic [7:0] bregs [32];
  logic [7:0] exp_regs [32];
  logic [7:0] exp_mem [DEPTH];
  int         exp_ptr = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic [7:0] ebuf [16];

  always #5 clk = ~clk;

  spi_regport_ram u_dut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata));

  // Register file on the far side of the port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) bregs[i] <= 8'h00;
    end else if (reg_we) begin
      bregs[reg_waddr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  always_comb reg_rdata = bregs[reg_raddr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction
  function automatic int adv_addr(input int a);
    return (a < 28) ? a + 1 : a;
  endfunction

  // Model of a write burst
  function automatic void model_wr(input int a0, input int n);
    int a = a0;
    for (int i = 0; i < n; i++) begin
      if (a < 26)       exp_regs[a] = wbuf[i];
      else if (a == 26) exp_ptr = (exp_ptr & 8'hFF) | (int'(wbuf[i][0]) << 8);
      else if (a == 27) exp_ptr = (exp_ptr & 32'h100) | int'(wbuf[i]);
      else if (a == 28) begin exp_mem[exp_ptr] = wbuf[i]; exp_ptr = nxt(exp_ptr); end
      a = adv_addr(a);
    end
  endfunction

  // Model of a read burst
  function automatic void model_rd(input int a0, input int n);
    int a = a0;
    for (int i = 0; i < n; i++) begin
      if (a < 26)       ebuf[i] = exp_regs[a];
      else if (a == 26) ebuf[i] = {7'b0, exp_ptr[8]};
      else if (a == 27) ebuf[i] = exp_ptr[7:0];
      else if (a == 28) ebuf[i] = 8'h00;
      else begin ebuf[i] = exp_mem[exp_ptr]; exp_ptr = nxt(exp_ptr); end
      a = adv_addr(a);
    end
  endfunction

  task automatic cs_on();
    @(negedge clk); spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask
  task automatic cs_off();
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      spi_mosi = din[i];
      dout[i]  = spi_miso;
      spi_sck  = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic wr_burst(input logic [7:0] cmd, input int n, output logic [7:0] cmd_rx);
    logic [7:0] d;
    cs_on();
    xfer(cmd, cmd_rx);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    cs_off();
  endtask

  task automatic rd_burst(input logic [7:0] cmd, input int n, output logic [7:0] cmd_rx);
    cs_on();
    xfer(cmd, cmd_rx);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    cs_off();
  endtask

  task automatic set_ptr(input int p);
    logic [7:0] c;
    wbuf[0] = {7'b0, p[8]};
    wbuf[1] = p[7:0];
    wr_burst(8'h20 | 8'h1A, 2, c);
    model_wr(26, 2);
  endtask

  task automatic check_rd(input string tag, input int a, input int n);
    logic [7:0] c;
    model_rd(a, n);
    rd_burst(8'hA0 | 8'(a), n, c);
    for (int i = 0; i < n; i++) chk(tag, rbuf[i], ebuf[i]);
  endtask

  initial begin
    logic [7:0] c;
    int st, n, we0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 32; i++) exp_regs[i] = 8'h00;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10/R11: reset state
    chk("R10 reset miso", spi_miso, 0);
    chk("R11 reset we", reg_we, 0);

    // Preload RAM to a known state through the port (R7: burst from 0x1A)
    for (int blk = 0; blk < DEPTH / 14; blk++) begin end
    set_ptr(0);
    for (int j = 0; j < 37; j++) begin
      for (int i = 0; i < 14; i++) wbuf[i] = 8'(j * 14 + i);
      wr_burst(8'h3C, 14, c);
      model_wr(28, 14);
    end
    set_ptr(0);
    check_rd("R4 preload", 29, 14);

    // R1/R2/R11: ordinary register write burst with auto-increment
    we0 = we_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_burst(8'h23, 3, c);
    model_wr(3, 3);
    chk("R10 cmd miso", c, 8'h00);
    chk("R2 reg3", bregs[3], exp_regs[3]);
    chk("R2 reg5", bregs[5], exp_regs[5]);
    chk("R11 strobes", we_cnt - we0, 3);
    check_rd("R2 readback", 3, 3);

    // R3: pointer registers written and read back
    set_ptr(9'h12C);
    check_rd("R3 ptr", 26, 2);

    // R7: one burst loads pointer then streams into RAM
    for (int i = 0; i < 7; i++) wbuf[i] = 8'hA0 + 8'(i);
    wbuf[0] = 8'h00; wbuf[1] = 8'h40;
    wr_burst(8'h3A, 7, c);
    model_wr(26, 7);
    check_rd("R7 ptr after", 26, 2);
    set_ptr(9'h040);
    check_rd("R7 stream data", 29, 5);
    check_rd("R4 ptr after read", 26, 2);

    // R2: read burst crossing into pointer registers
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    wr_burst(8'h38, 2, c);
    model_wr(24, 2);
    check_rd("R2 cross", 24, 4);

    // R5: pointer wrap on write and read
    set_ptr(9'h1FE);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hE0 + 8'(i);
    wr_burst(8'h3C, 4, c);
    model_wr(28, 4);
    check_rd("R5 wrap ptr", 26, 2);
    set_ptr(9'h1FF);
    check_rd("R5 wrap read", 29, 3);

    // R6: malformed commands are inert
    we0 = we_cnt;
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    wr_burst(8'h03, 2, c);
    wr_burst(8'h3E, 2, c);
    wr_burst(8'h63, 2, c);
    wr_burst(8'h7C, 2, c);
    rd_burst(8'hBE, 2, c);
    chk("R6 miso b0", rbuf[0], 8'h00);
    chk("R6 miso b1", rbuf[1], 8'h00);
    chk("R6 no strobe", we_cnt - we0, 0);
    chk("R6 reg3", bregs[3], exp_regs[3]);
    check_rd("R6 ptr", 26, 2);

    // R8: write to 0x1D is inert, read of 0x1C is zero
    set_ptr(9'h0AA);
    wbuf[0] = 8'h77; wbuf[1] = 8'h78;
    wr_burst(8'h3D, 2, c);
    check_rd("R8 ptr after wr1D", 26, 2);
    check_rd("R8 read1C", 28, 2);
    check_rd("R8 ptr after rd1C", 26, 2);
    check_rd("R8 mem", 29, 1);

    // R9: eighth edge coincides with chip-select release
    we0 = we_cnt;
    cs_on();
    xfer(8'h27, c);
    for (int i = 7; i >= 1; i--) begin
      @(negedge clk); spi_mosi = 1'b1; spi_sck = 1'b1;
      repeat (HALF) @(negedge clk); spi_sck = 1'b0;
      repeat (HALF - 1) @(negedge clk);
    end
    @(negedge clk); spi_mosi = 1'b1; spi_sck = 1'b1; spi_csn = 1'b1;
    repeat (HALF) @(negedge clk); spi_sck = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    chk("R9 no strobe", we_cnt - we0, 0);
    check_rd("R9 reg7", 7, 1);

    // Random mix of register and RAM bursts
    for (int it = 0; it < 12; it++) begin
      st = $urandom_range(0, 21);
      n  = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_burst(8'h20 | 8'(st), n, c);
      model_wr(st, n);
      check_rd("R2 random", st, n);
      st = $urandom_range(0, DEPTH - 1);
      n  = $urandom_range(1, 8);
      set_ptr(st);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_burst(8'h3C, n, c);
      model_wr(28, n);
      set_ptr(st);
      check_rd("R4 random", 29, n);
      check_rd("R5 random ptr", 26, 2);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule